// File: doc/BRIEF.md
# Big-endian to little-endian byte-lane steering bridge

This block connects a processor data port that counts bytes from the most significant end to a 32-bit memory-mapped slave bus whose byte enables count lanes from the least significant end. The processor issues one request at a time. Each request carries a byte address, an access size code (byte, halfword or word), a write flag and a right-justified write value. The bridge turns it into a single bus command with the matching byte enables and lane-placed data.

A single byte always lands on the same physical lane that a little-endian master would use. Multibyte write values are byte-reversed across their enabled lanes, so the byte the processor thinks of as first (its most significant byte) sits on the lowest enabled lane. On reads, the enabled lanes are gathered back into a right-justified result. In that result, the higher-numbered lane is the more significant byte, so a little-endian peripheral's counter value arrives with its arithmetic meaning intact. Sizes and offsets that do not fit a naturally aligned slot are refused locally with an error response, and no bus command is issued for them.

The bus side holds each command steady while the slave stalls it with waitrequest. Read data is taken when readdatavalid is asserted. The result is returned as a one-cycle response pulse.

Top module: `be_lane_bridge`

## Requirements
- R1: A synchronous active-high `rst` returns the block to idle. In the cycle after reset, `req_ready`=1, while `bus_read`, `bus_write`, `rsp_valid` and `bus_byteenable` are all 0.
- R2: Size code 0 (byte) at offset n=`req_addr[1:0]` asserts only byte-enable bit n. It places `req_wdata[7:0]` on `bus_writedata[8n+7:8n]`, and every other lane is zero.
- R3: Size code 1 (halfword) at offset 0 asserts byte enables 4'b0011, with `req_wdata[15:8]` on bits 7:0 and `req_wdata[7:0]` on bits 15:8. At offset 2 it asserts 4'b1100, with `req_wdata[15:8]` on bits 23:16 and `req_wdata[7:0]` on bits 31:24.
- R4: Size code 2 (word) at offset 0 asserts 4'b1111 and reverses all four bytes: a value of 0x0A0B0C0D is driven as writedata 0x0D0C0B0A.
- R5: The following requests are refused: a halfword with an odd offset, a word with a nonzero offset, or size code 3. No `bus_read` or `bus_write` is issued. In the cycle after acceptance, `rsp_valid`=1 and `rsp_error`=1.
- R6: While a command is on the bus and `bus_waitrequest` is 1, the command stays asserted, and `bus_address`, `bus_byteenable` and `bus_writedata` stay unchanged on the next cycle.
- R7: A write completes in a cycle where it is on the bus and `bus_waitrequest` is 0. `rsp_valid`=1 with `rsp_error`=0 follows in the next cycle.
- R8: Read data is captured in a cycle where `bus_readdatavalid`=1, and `rsp_valid` follows in the next cycle. `rsp_rdata` holds the enabled lanes, right-justified, with the higher-numbered lane as the more significant byte and all unused upper bits zero. For example, a halfword read at offset 0 with lane 1 = 0x08 and lane 0 = 0x00 returns 0x0800.
- R9: `rsp_valid` is a single-cycle pulse, one per accepted request.
- R10: `req_ready` is high only when idle, and a request is accepted when `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance through the response cycle, and a legal request produces exactly one completed bus command.
- R11: `bus_address` equals the accepted `req_addr` with its two low bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Bridge idle, can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 refused |
| req_addr | input | 32 | Byte address; low two bits are the offset |
| req_wdata | input | 32 | Right-justified write value |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_error | output | 1 | Request was refused |
| rsp_rdata | output | 32 | Right-justified read result, zero otherwise |
| bus_address | output | 32 | Word-aligned bus address |
| bus_read | output | 1 | Bus read command |
| bus_write | output | 1 | Bus write command |
| bus_byteenable | output | 4 | Lane enables, bit n = bits 8n+7:8n |
| bus_writedata | output | 32 | Lane-placed write data |
| bus_waitrequest | input | 1 | Slave stall |
| bus_readdatavalid | input | 1 | Read data present |
| bus_readdata | input | 32 | Read data lanes |

## Verification
Two events can fall in the same cycle: the response pulse of one transaction and a processor that is already presenting its next request. To provoke this, the bench keeps `req_valid` asserted after acceptance in about half of the transactions, until the response pulse arrives. Meanwhile, the random slave stalls with `bus_waitrequest` and delays `bus_readdatavalid` by one to three cycles. The overlap is judged correct if `req_ready` stays low through the response cycle, each transaction counts exactly one completed bus command, and that command carries the expected lanes. Response timing is measured against the cycle of bus completion or data capture.

// File: rtl/be_lane_pkg.sv
package be_lane_pkg;
  localparam int BUS_BYTES = 4;
  localparam int SIZE_W    = 2;

  typedef enum logic [1:0] {XS_IDLE, XS_CMD, XS_RDW, XS_RSP} xfer_state_e;

  // number of bytes moved by a size code
  function automatic int span_bytes(input logic [SIZE_W-1:0] sz);
    return int'(1) << sz;
  endfunction

  // naturally aligned and no wider than the bus
  function automatic logic access_legal(input logic [SIZE_W-1:0] sz, input int off, input int bytes);
    int n;
    n = span_bytes(sz);
    return (n <= bytes) && ((off % n) == 0);
  endfunction

  // value byte that feeds a lane on writes (first byte = most significant), -1 if idle lane
  function automatic int src_byte(input int lane, input int off, input int n);
    if (lane < off || lane >= off + n) return -1;
    return n - 1 - (lane - off);
  endfunction

  // lane that feeds result byte j on reads (higher lane = more significant), -1 if unused
  function automatic int gather_lane(input int j, input int off, input int n);
    if (j >= n) return -1;
    return off + j;
  endfunction
endpackage

// File: rtl/be_wr_steer.sv
module be_wr_steer
  import be_lane_pkg::*;
#(
  parameter int BYTES = BUS_BYTES,
  localparam int OW = $clog2(BYTES),
  localparam int DW = 8 * BYTES
) (
  input  logic [SIZE_W-1:0] acc_size,
  input  logic [OW-1:0]     acc_off,
  input  logic [DW-1:0]     acc_value,
  output logic [BYTES-1:0]  lane_en,
  output logic [DW-1:0]     lane_data
);
  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    int src;
    logic hit;
    logic [OW-1:0] sel;
    always_comb begin
      src = src_byte(i, int'(acc_off), span_bytes(acc_size));
      hit = (src >= 0) && (src < BYTES);
      sel = OW'(src);
    end
    assign lane_en[i] = hit;
    assign lane_data[8*i +: 8] = hit ? acc_value[8*sel +: 8] : 8'h00;
  end
endmodule

// File: rtl/be_rd_gather.sv
module be_rd_gather
  import be_lane_pkg::*;
#(
  parameter int BYTES = BUS_BYTES,
  localparam int OW = $clog2(BYTES),
  localparam int DW = 8 * BYTES
) (
  input  logic [SIZE_W-1:0] acc_size,
  input  logic [OW-1:0]     acc_off,
  input  logic [DW-1:0]     lane_word,
  output logic [DW-1:0]     value
);
  for (genvar j = 0; j < BYTES; j++) begin : g_byte
    int src;
    logic hit;
    logic [OW-1:0] sel;
    always_comb begin
      src = gather_lane(j, int'(acc_off), span_bytes(acc_size));
      hit = (src >= 0) && (src < BYTES);
      sel = OW'(src);
    end
    assign value[8*j +: 8] = hit ? lane_word[8*sel +: 8] : 8'h00;
  end
endmodule

// File: rtl/be_xfer_ctrl.sv
module be_xfer_ctrl
  import be_lane_pkg::*;
#(
  parameter int BYTES  = BUS_BYTES,
  parameter int ADDR_W = 32,
  localparam int OW = $clog2(BYTES),
  localparam int DW = 8 * BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_legal,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [BYTES-1:0]  req_lanes,
  input  logic [DW-1:0]     req_lane_data,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_error,
  output logic              rsp_is_read,
  output logic [SIZE_W-1:0] held_size,
  output logic [OW-1:0]     held_off,
  output logic [DW-1:0]     held_word,
  output logic [ADDR_W-1:0] bus_address,
  output logic              bus_read,
  output logic              bus_write,
  output logic [BYTES-1:0]  bus_byteenable,
  output logic [DW-1:0]     bus_writedata,
  input  logic              bus_waitrequest,
  input  logic              bus_readdatavalid,
  input  logic [DW-1:0]     bus_readdata
);
  xfer_state_e       state;
  logic              wr_q, err_q;
  logic [SIZE_W-1:0] size_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTES-1:0]  be_q;
  logic [DW-1:0]     wd_q, word_q;

  // named internal events
  logic accept_evt, reject_evt, cmd_done_evt, rd_capture_evt;
  assign accept_evt     = (state == XS_IDLE) && req_valid;
  assign reject_evt     = accept_evt && !req_legal;
  assign cmd_done_evt   = (state == XS_CMD) && !bus_waitrequest;
  assign rd_capture_evt = (state == XS_RDW) && bus_readdatavalid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= XS_IDLE;
      wr_q   <= 1'b0;
      err_q  <= 1'b0;
      size_q <= '0;
      addr_q <= '0;
      be_q   <= '0;
      wd_q   <= '0;
      word_q <= '0;
    end else begin
      case (state)
        XS_IDLE: if (accept_evt) begin
          wr_q   <= req_write;
          err_q  <= !req_legal;
          size_q <= req_size;
          addr_q <= req_addr;
          be_q   <= req_lanes;
          wd_q   <= req_write ? req_lane_data : '0;
          word_q <= '0;
          state  <= req_legal ? XS_CMD : XS_RSP;
        end
        XS_CMD: if (cmd_done_evt) state <= wr_q ? XS_RSP : XS_RDW;
        XS_RDW: if (rd_capture_evt) begin
          word_q <= bus_readdata;
          state  <= XS_RSP;
        end
        XS_RSP:  state <= XS_IDLE;
        default: state <= XS_IDLE;
      endcase
    end
  end

  assign req_ready      = (state == XS_IDLE);
  assign rsp_valid      = (state == XS_RSP);
  assign rsp_error      = rsp_valid && err_q;
  assign rsp_is_read    = !wr_q && !err_q;
  assign held_size      = size_q;
  assign held_off       = addr_q[OW-1:0];
  assign held_word      = word_q;
  assign bus_read       = (state == XS_CMD) && !wr_q;
  assign bus_write      = (state == XS_CMD) && wr_q;
  assign bus_byteenable = (state == XS_CMD) ? be_q : '0;
  assign bus_writedata  = wd_q;
  assign bus_address    = {addr_q[ADDR_W-1:OW], {OW{1'b0}}};

  // R1
  idle_after_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (req_ready && !bus_read && !bus_write && !rsp_valid && bus_byteenable == '0));
  // R5
  reject_no_bus_chk: assert property (@(posedge clk) disable iff (rst)
    reject_evt |=> (!bus_read && !bus_write && rsp_valid && rsp_error));
  // R6
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    ((bus_read || bus_write) && bus_waitrequest) |=>
      ((bus_read || bus_write) && $stable(bus_address) && $stable(bus_byteenable) && $stable(bus_writedata)));
  // R7
  write_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_write && !bus_waitrequest) |=> (rsp_valid && !rsp_error));
  // R8
  read_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    rd_capture_evt |=> (rsp_valid && !rsp_error));
  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R10
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!bus_read && !bus_write && !rsp_valid));
  // R2
  lanes_present_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_read || bus_write) |-> (bus_byteenable != '0));
endmodule

// File: rtl/be_lane_bridge.sv
module be_lane_bridge
  import be_lane_pkg::*;
#(
  parameter int BYTES  = BUS_BYTES,
  parameter int ADDR_W = 32,
  localparam int OW = $clog2(BYTES),
  localparam int DW = 8 * BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic              rsp_error,
  output logic [DW-1:0]     rsp_rdata,
  output logic [ADDR_W-1:0] bus_address,
  output logic              bus_read,
  output logic              bus_write,
  output logic [BYTES-1:0]  bus_byteenable,
  output logic [DW-1:0]     bus_writedata,
  input  logic              bus_waitrequest,
  input  logic              bus_readdatavalid,
  input  logic [DW-1:0]     bus_readdata
);
  logic              legal;
  logic [BYTES-1:0]  steer_en;
  logic [DW-1:0]     steer_data;
  logic              is_read;
  logic [SIZE_W-1:0] h_size;
  logic [OW-1:0]     h_off;
  logic [DW-1:0]     h_word;
  logic [DW-1:0]     gathered;

  assign legal = access_legal(req_size, int'(req_addr[OW-1:0]), BYTES);

  be_wr_steer #(.BYTES(BYTES)) u_steer (
    .acc_size (req_size),
    .acc_off  (req_addr[OW-1:0]),
    .acc_value(req_wdata),
    .lane_en  (steer_en),
    .lane_data(steer_data)
  );

  be_xfer_ctrl #(.BYTES(BYTES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk              (clk),
    .rst              (rst),
    .req_valid        (req_valid),
    .req_write        (req_write),
    .req_legal        (legal),
    .req_addr         (req_addr),
    .req_size         (req_size),
    .req_lanes        (steer_en),
    .req_lane_data    (steer_data),
    .req_ready        (req_ready),
    .rsp_valid        (rsp_valid),
    .rsp_error        (rsp_error),
    .rsp_is_read      (is_read),
    .held_size        (h_size),
    .held_off         (h_off),
    .held_word        (h_word),
    .bus_address      (bus_address),
    .bus_read         (bus_read),
    .bus_write        (bus_write),
    .bus_byteenable   (bus_byteenable),
    .bus_writedata    (bus_writedata),
    .bus_waitrequest  (bus_waitrequest),
    .bus_readdatavalid(bus_readdatavalid),
    .bus_readdata     (bus_readdata)
  );

  be_rd_gather #(.BYTES(BYTES)) u_gather (
    .acc_size (h_size),
    .acc_off  (h_off),
    .lane_word(h_word),
    .value    (gathered)
  );

  assign rsp_rdata = (rsp_valid && is_read) ? gathered : '0;

  // R8
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!rsp_valid || rsp_error) |-> (rsp_rdata == '0));
endmodule

// File: tb/test_be_lane_bridge.sv
`timescale 1ns/1ps
module test_be_lane_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_error;
  logic [31:0] rsp_rdata, bus_address, bus_writedata;
  logic        bus_read, bus_write;
  logic [3:0]  bus_byteenable;
  logic        bus_waitrequest = 1'b1, bus_readdatavalid = 1'b0;
  logic [31:0] bus_readdata = '0;

  be_lane_bridge i_be_lane_bridge (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int cmd_cnt = 0, done_cyc = 0, pend = 0;
  bit held = 0;
  logic [3:0]  sv_be, cap_be;
  logic [31:0] sv_wd, sv_addr, cap_wd, cap_addr, slave_word;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] x_be(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      2'd0: return 4'b0001 << off;
      2'd1: return 4'b0011 << off;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] x_wd(input logic [1:0] sz, input logic [1:0] off, input logic [31:0] v);
    case (sz)
      2'd0: return {24'h0, v[7:0]} << (8 * off);
      2'd1: return {16'h0, v[7:0], v[15:8]} << (8 * off);
      default: return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endcase
  endfunction

  function automatic logic [31:0] x_rd(input logic [1:0] sz, input logic [1:0] off, input logic [31:0] w);
    case (sz)
      2'd0: return (w >> (8 * off)) & 32'hFF;
      2'd1: return (w >> (8 * off)) & 32'hFFFF;
      default: return w;
    endcase
  endfunction

  function automatic bit x_ok(input logic [1:0] sz, input logic [1:0] off);
    return (sz == 2'd0) || (sz == 2'd1 && !off[0]) || (sz == 2'd2 && off == 2'd0);
  endfunction

  // random slave, driven away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      bus_waitrequest = 1'b1; bus_readdatavalid = 1'b0; pend = 0; held = 0;
    end else begin
      if (held)  // R6 command must still be present and unchanged
        chk((bus_read || bus_write) && bus_byteenable == sv_be && bus_writedata == sv_wd
            && bus_address == sv_addr, "R6 hold", {bus_byteenable, bus_writedata[27:0]}, {sv_be, sv_wd[27:0]});
      bus_readdatavalid = 1'b0;
      bus_readdata = $urandom;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          bus_readdatavalid = 1'b1; bus_readdata = slave_word; done_cyc = cyc;
        end
      end
      if (bus_read || bus_write) begin
        if ($urandom % 2 == 1) begin
          bus_waitrequest = 1'b1; held = 1;
          sv_be = bus_byteenable; sv_wd = bus_writedata; sv_addr = bus_address;
        end else begin
          bus_waitrequest = 1'b0; held = 0; cmd_cnt++; done_cyc = cyc;
          cap_be = bus_byteenable; cap_wd = bus_writedata; cap_addr = bus_address;
          if (bus_read) pend = 1 + ($urandom % 3);
        end
      end else begin
        bus_waitrequest = 1'($urandom % 2); held = 0;
      end
    end
  end

  task automatic txn(input bit wr, input logic [1:0] sz, input logic [1:0] off,
                     input logic [31:0] val, input logic [31:0] word, input bit hold);
    logic [31:0] a;
    int n0, acc_cyc, k;
    bit ok;
    a = {$urandom} & 32'hFFFF_FFFC | {30'h0, off};
    ok = x_ok(sz, off);
    slave_word = word;
    @(negedge clk);
    chk(req_ready, "R10 ready idle", {31'h0, req_ready}, 32'h1);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = val;
    n0 = cmd_cnt; acc_cyc = cyc;
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    k = 0;
    while (!rsp_valid && k < 60) begin
      chk(!req_ready, "R10 busy", {31'h0, req_ready}, 32'h0);
      @(negedge clk); k++;
    end
    chk(rsp_valid, "R9 response seen", {31'h0, rsp_valid}, 32'h1);
    chk(!req_ready, "R10 busy in response", {31'h0, req_ready}, 32'h0);
    req_valid = 1'b0;
    if (!ok) begin
      chk(rsp_error, "R5 error flag", {31'h0, rsp_error}, 32'h1);
      chk(cmd_cnt == n0, "R5 no bus cycle", cmd_cnt, n0);
      chk(cyc == acc_cyc + 1, "R5 timing", cyc, acc_cyc + 1);
    end else begin
      chk(!rsp_error, "R7 R8 no error", {31'h0, rsp_error}, 32'h0);
      chk(cmd_cnt == n0 + 1, "R10 one command", cmd_cnt, n0 + 1);
      chk(cyc == done_cyc + 1, wr ? "R7 timing" : "R8 timing", cyc, done_cyc + 1);
      chk(cap_addr == {a[31:2], 2'b00}, "R11 address", cap_addr, {a[31:2], 2'b00});
      chk(cap_be == x_be(sz, off), "R2 R3 R4 byteenable", {28'h0, cap_be}, {28'h0, x_be(sz, off)});
      if (wr) chk(cap_wd == x_wd(sz, off, val), "R2 R3 R4 writedata", cap_wd, x_wd(sz, off, val));
      else    chk(rsp_rdata == x_rd(sz, off, word), "R8 readdata", rsp_rdata, x_rd(sz, off, word));
    end
    @(negedge clk);
    chk(!rsp_valid, "R9 pulse ends", {31'h0, rsp_valid}, 32'h0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !bus_read && !bus_write && !rsp_valid && bus_byteenable == 4'h0,
        "R1 reset idle", {bus_read, bus_write, rsp_valid, bus_byteenable}, 32'h0);
    // R2 bytes on each lane
    for (int o = 0; o < 4; o++) txn(1'b1, 2'd0, 2'(o), 32'h0000_000A, 32'h0, 1'b0);
    // R3 halfwords, R4 word
    txn(1'b1, 2'd1, 2'd0, 32'h0000_0A0B, 32'h0, 1'b0);
    txn(1'b1, 2'd1, 2'd2, 32'h0000_0A0B, 32'h0, 1'b1);
    txn(1'b1, 2'd2, 2'd0, 32'h0A0B_0C0D, 32'h0, 1'b0);
    // R5 refused shapes
    txn(1'b1, 2'd1, 2'd1, 32'h1234, 32'h0, 1'b0);
    txn(1'b0, 2'd2, 2'd2, 32'h0, 32'h0, 1'b1);
    txn(1'b0, 2'd3, 2'd0, 32'h0, 32'h0, 1'b0);
    // R8 little-endian counter value
    txn(1'b0, 2'd1, 2'd0, 32'h0, 32'hA5C3_0800, 1'b0);
    txn(1'b0, 2'd2, 2'd0, 32'h0, 32'h0D0C_0B0A, 1'b1);
    // rst mid-run, then R1 again
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    chk(req_ready && bus_byteenable == 4'h0 && !rsp_valid, "R1 re-reset", {28'h0, bus_byteenable}, 32'h0);
    for (int t = 0; t < 300; t++)
      txn(1'($urandom % 2), 2'($urandom % 4), 2'($urandom % 4), $urandom, $urandom, 1'($urandom % 2));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule